// File: doc/BRIEF.md
# ADC Sample FIFO with Active-Low Flags

This block buffers results from an analog-to-digital converter until a host reads them. Each completed conversion pushes one 16-bit word. Each host read of the data register pops one word. The buffer holds 1024 words by default. The host watches three occupancy flags in a status byte: full, half-full and empty. Each flag reads 0 when its condition holds. The same byte also carries a converter-busy bit and the current 3-bit gain code, both passed through from outside the block.

The host cannot clear the buffer with a single strobe. It must write the FIFO-enable control bit as 0, then 1, then 0, and only the final write of that sequence empties the storage. A control write also sets a routing bit. When the routing bit is 1, the moment occupancy crosses up to the half-full level latches an interrupt request. That request stays high until the host writes to a separate clear strobe. A push that arrives while the buffer is full is discarded, and a sticky overflow flag records the loss.

Top module: `adc_sample_fifo`

## Requirements
- R1: Words pushed with `cnv_valid` are returned in arrival order. A word appears on `rd_data` in the cycle after the `rd_pop` cycle that takes it.
- R2: When 1024 words (DEPTH) are held, status bit 6 (full) reads 0. At any lower occupancy it reads 1.
- R3: When no word is held, status bit 4 (empty) reads 0. Otherwise it reads 1.
- R4: When occupancy is 512 (DEPTH/2) or more, status bit 5 (half-full) reads 0. It returns to 1 as soon as occupancy falls below 512.
- R5: Status bit 7 equals `cnv_busy`, bits 2:0 equal `gain_code`, and bit 3 reads 0.
- R6: A push while the buffer is full is dropped and sets `overflow`. The flag stays set until the clear sequence completes.
- R7: A pop while the buffer is empty leaves `rd_data` unchanged and moves no pointer. The next word pushed is the next word popped.
- R8: The buffer, and `overflow` with it, is cleared only by three consecutive control writes with `ctl_fifo_en` equal to 0, then 1, then 0. Any number of repeated writes of 1 may sit between the 0 and the 1. A 1-then-0 pair with no leading 0 does not clear.
- R9: When the routing bit is 1, the rise of the half-full condition sets `irq_hf`. The request then holds even if occupancy drops back below half.
- R10: A pulse on `irq_clr` drops `irq_hf`.
- R11: The routing bit is loaded from `ctl_hf_route` on each control write and is 0 after reset. While it is 0, reaching half-full raises no request.
- R12: After reset, status reads 0x60 with busy and gain at 0, `rd_data` is 0, and `irq_hf` and `overflow` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnv_valid | input | 1 | Conversion finished, push `cnv_data` |
| cnv_data | input | 16 | Converter result word |
| cnv_busy | input | 1 | Converter busy, reported in status bit 7 |
| gain_code | input | 3 | Gain/range code, reported in status bits 2:0 |
| rd_pop | input | 1 | Host read of the data register, pops one word |
| rd_data | output | 16 | Last popped word |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_fifo_en | input | 1 | FIFO-enable bit of the control write |
| ctl_hf_route | input | 1 | Half-full interrupt routing bit of the control write |
| irq_clr | input | 1 | Write to the interrupt clear address |
| status | output | 8 | Status byte: busy, full_n, half_n, empty_n, 0, gain |
| overflow | output | 1 | Sticky: a push was dropped while full |
| irq_hf | output | 1 | Half-full interrupt request |

## Verification
The hardest state to reach is a completely full buffer: a push into it must be dropped, and then all 1024 entries must drain in order with the pointers wrapped exactly once. The bench streams a computed pattern into the buffer on consecutive cycles until it is full. It then pushes one extra, distinct word and drains every entry, comparing each against the pattern. The interrupt edge at exactly 511→512 entries is reached the same way: a burst of 511 pushes followed by a single push, then a pop and another push to re-cross the threshold.

// File: rtl/adc_fifo_pkg.sv
package adc_fifo_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_LOW  = 2'd1,
        SEQ_HIGH = 2'd2
    } clr_seq_e;

    localparam int STAT_BUSY  = 7;
    localparam int STAT_FULL  = 6;
    localparam int STAT_HALF  = 5;
    localparam int STAT_EMPTY = 4;

endpackage

// File: rtl/fifo_clear_seq.sv
module fifo_clear_seq
    import adc_fifo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic en_bit,
    output logic wipe
);

    clr_seq_e seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        wipe  = 1'b0;
        if (wr) begin
            if (!en_bit) begin
                wipe  = (seq_q == SEQ_HIGH);
                seq_d = SEQ_LOW;
            end else begin
                seq_d = (seq_q == SEQ_IDLE) ? SEQ_IDLE : SEQ_HIGH;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= SEQ_IDLE;
        else        seq_q <= seq_d;
    end

endmodule

// File: rtl/fifo_store.sv
module fifo_store #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 1024,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rd_d, rd_q;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    always_comb begin
        rd_d = rd_q;
        if (rd_en) rd_d = mem[rd_addr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/fifo_irq_ctrl.sv
module fifo_irq_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic half_lvl,
    input  logic route_en,
    input  logic clr,
    output logic irq
);

    typedef struct packed {
        logic prev;
        logic pend;
    } irq_st_t;

    irq_st_t st_d, st_q;
    logic    rise;

    always_comb begin
        st_d      = st_q;
        rise      = half_lvl && !st_q.prev;
        st_d.prev = half_lvl;
        if (rise && route_en) st_d.pend = 1'b1;
        else if (clr)         st_d.pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq = st_q.pend;

endmodule

// File: rtl/adc_sample_fifo.sv
module adc_sample_fifo
    import adc_fifo_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 1024,
    parameter int GAIN_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnv_valid,
    input  logic [DATA_W-1:0] cnv_data,
    input  logic              cnv_busy,
    input  logic [GAIN_W-1:0] gain_code,
    input  logic              rd_pop,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ctl_wr,
    input  logic              ctl_fifo_en,
    input  logic              ctl_hf_route,
    input  logic              irq_clr,
    output logic [7:0]        status,
    output logic              overflow,
    output logic              irq_hf
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
    localparam logic [CW-1:0] HALF_C = CW'(DEPTH / 2);

    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [CW-1:0] count;
        logic          ovf;
        logic          route;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     wipe;
    logic     push_ok, pop_ok;
    logic     is_full, is_empty, is_half;

    assign is_full  = (st_q.count == FULL_C);
    assign is_empty = (st_q.count == '0);
    assign is_half  = (st_q.count >= HALF_C);

    fifo_clear_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (ctl_wr),
        .en_bit (ctl_fifo_en),
        .wipe   (wipe)
    );

    always_comb begin
        st_d    = st_q;
        push_ok = cnv_valid && !is_full && !wipe;
        pop_ok  = rd_pop && !is_empty && !wipe;
        if (ctl_wr) st_d.route = ctl_hf_route;
        if (wipe) begin
            st_d.wr_ptr = '0;
            st_d.rd_ptr = '0;
            st_d.count  = '0;
            st_d.ovf    = 1'b0;
        end else begin
            if (push_ok) st_d.wr_ptr = st_q.wr_ptr + 1'b1;
            if (pop_ok)  st_d.rd_ptr = st_q.rd_ptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   st_d.count = st_q.count + 1'b1;
                2'b01:   st_d.count = st_q.count - 1'b1;
                default: st_d.count = st_q.count;
            endcase
            if (cnv_valid && is_full) st_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    fifo_store #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (push_ok),
        .wr_addr (st_q.wr_ptr),
        .wr_data (cnv_data),
        .rd_en   (pop_ok),
        .rd_addr (st_q.rd_ptr),
        .rd_data (rd_data)
    );

    fifo_irq_ctrl u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .half_lvl (is_half),
        .route_en (st_q.route),
        .clr      (irq_clr),
        .irq      (irq_hf)
    );

    always_comb begin
        status             = '0;
        status[STAT_BUSY]  = cnv_busy;
        status[STAT_FULL]  = !is_full;
        status[STAT_HALF]  = !is_half;
        status[STAT_EMPTY] = !is_empty;
        status[GAIN_W-1:0] = gain_code;
    end

    assign overflow = st_q.ovf;

endmodule

// File: rtl/adc_sample_fifo_chk.sv
module adc_sample_fifo_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cnv_valid,
    input logic        rd_pop,
    input logic        ctl_wr,
    input logic        irq_clr,
    input logic [7:0]  status,
    input logic [15:0] rd_data,
    input logic        overflow,
    input logic        irq_hf,
    input logic        wipe
);

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[6] && cnv_valid && !rd_pop && !ctl_wr) |=> (!status[6] && overflow)); // R6

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !wipe) |=> overflow); // R6

    AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[4] && rd_pop) |=> $stable(rd_data)); // R7

    AST_FULL_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !(!status[6] && !status[4])); // R2

    AST_FULL_IS_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        !status[6] |-> !status[5]); // R4

    AST_WIPE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        wipe |=> (!status[4] && !overflow)); // R8

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_hf && !irq_clr) |=> irq_hf); // R9

    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && status[5]) |=> !irq_hf); // R10

endmodule

bind adc_sample_fifo adc_sample_fifo_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnv_valid (cnv_valid),
    .rd_pop    (rd_pop),
    .ctl_wr    (ctl_wr),
    .irq_clr   (irq_clr),
    .status    (status),
    .rd_data   (rd_data),
    .overflow  (overflow),
    .irq_hf    (irq_hf),
    .wipe      (wipe)
);

// File: tb/adc_sample_fifo_bench.sv
module adc_sample_fifo_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnv_valid = 1'b0;
    logic [15:0] cnv_data = '0;
    logic        cnv_busy = 1'b0;
    logic [2:0]  gain_code = '0;
    logic        rd_pop = 1'b0;
    logic [15:0] rd_data;
    logic        ctl_wr = 1'b0;
    logic        ctl_fifo_en = 1'b0;
    logic        ctl_hf_route = 1'b0;
    logic        irq_clr = 1'b0;
    logic [7:0]  status;
    logic        overflow;
    logic        irq_hf;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    adc_sample_fifo u_adc_sample_fifo (
        .clk          (clk),
        .rst_n        (rst_n),
        .cnv_valid    (cnv_valid),
        .cnv_data     (cnv_data),
        .cnv_busy     (cnv_busy),
        .gain_code    (gain_code),
        .rd_pop       (rd_pop),
        .rd_data      (rd_data),
        .ctl_wr       (ctl_wr),
        .ctl_fifo_en  (ctl_fifo_en),
        .ctl_hf_route (ctl_hf_route),
        .irq_clr      (irq_clr),
        .status       (status),
        .overflow     (overflow),
        .irq_hf       (irq_hf)
    );

    function automatic logic [15:0] pat(input int i);
        return 16'(i * 37 + 16'h1234);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_burst(input int n, input int base);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cnv_valid = 1'b1;
            cnv_data  = pat(base + i);
        end
        @(negedge clk);
        cnv_valid = 1'b0;
    endtask

    task automatic push_one(input logic [15:0] d);
        @(negedge clk);
        cnv_valid = 1'b1;
        cnv_data  = d;
        @(negedge clk);
        cnv_valid = 1'b0;
    endtask

    task automatic pop_one();
        @(negedge clk);
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
    endtask

    task automatic ctl_write(input logic en, input logic route);
        @(negedge clk);
        ctl_wr       = 1'b1;
        ctl_fifo_en  = en;
        ctl_hf_route = route;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic clr_pulse();
        @(negedge clk);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    task automatic wipe_all(input logic route);
        ctl_write(1'b0, route);
        ctl_write(1'b1, route);
        ctl_write(1'b0, route);
    endtask

    task automatic t_reset_state();
        chk("R12 status", status, 8'h60);
        chk("R12 rd_data", rd_data, 0);
        chk("R12 irq", irq_hf, 0);
        chk("R12 overflow", overflow, 0);
        chk("R3 empty flag low", status[4], 0);
    endtask

    task automatic t_status_inputs();
        @(negedge clk);
        cnv_busy  = 1'b1;
        gain_code = 3'd5;
        #1;
        chk("R5 busy and gain", status, 8'hE5);
        @(negedge clk);
        cnv_busy  = 1'b0;
        gain_code = 3'd2;
        #1;
        chk("R5 gain only", status, 8'h62);
        gain_code = 3'd0;
    endtask

    task automatic t_order();
        push_burst(5, 100);
        chk("R3 not empty", status[4], 1);
        chk("R4 below half", status[5], 1);
        for (int i = 0; i < 5; i++) begin
            pop_one();
            chk("R1 order", rd_data, pat(100 + i));
        end
        chk("R3 empty again", status[4], 0);
    endtask

    task automatic t_empty_pop();
        logic [15:0] last;
        last = rd_data;
        pop_one();
        chk("R7 empty pop holds data", rd_data, last);
        chk("R7 still empty", status[4], 0);
        push_one(16'hBEEF);
        pop_one();
        chk("R7 next push is next pop", rd_data, 16'hBEEF);
        chk("R7 empty after", status[4], 0);
    endtask

    task automatic t_clear_seq();
        push_burst(3, 200);
        ctl_write(1'b1, 1'b0);
        ctl_write(1'b0, 1'b0);
        chk("R8 1-0 pair does not clear", status[4], 1);
        ctl_write(1'b1, 1'b0);
        ctl_write(1'b1, 1'b0);
        chk("R8 no clear before final 0", status[4], 1);
        ctl_write(1'b0, 1'b0);
        chk("R8 0-1-0 clears", status[4], 0);
        pop_one();
        chk("R8 cleared pop holds", rd_data, 16'hBEEF);
    endtask

    task automatic t_no_route();
        push_burst(512, 300);
        idle(2);
        chk("R4 half at 512", status[5], 0);
        chk("R11 route off no irq", irq_hf, 0);
        wipe_all(1'b0);
        chk("R8 wipe from half", status[4], 0);
    endtask

    task automatic t_half_irq();
        ctl_write(1'b0, 1'b1);
        push_burst(511, 400);
        idle(1);
        chk("R4 not half at 511", status[5], 1);
        chk("R9 no irq at 511", irq_hf, 0);
        push_one(16'h0511);
        idle(1);
        chk("R4 half at 512", status[5], 0);
        chk("R9 irq on half rise", irq_hf, 1);
        pop_one();
        idle(1);
        chk("R4 below half after pop", status[5], 1);
        chk("R9 irq held below half", irq_hf, 1);
        clr_pulse();
        chk("R10 clear drops irq", irq_hf, 0);
        push_one(16'h0512);
        idle(1);
        chk("R9 irq on second rise", irq_hf, 1);
        clr_pulse();
        chk("R10 second clear", irq_hf, 0);
        wipe_all(1'b0);
        clr_pulse();
    endtask

    task automatic t_full();
        int bad;
        push_burst(1024, 1000);
        chk("R2 full flag low", status[6], 0);
        chk("R4 half while full", status[5], 0);
        chk("R6 no overflow yet", overflow, 0);
        push_one(16'hDEAD);
        chk("R6 overflow set", overflow, 1);
        chk("R2 still full", status[6], 0);
        pop_one();
        chk("R2 not full after pop", status[6], 1);
        chk("R1 first after wrap", rd_data, pat(1000));
        bad = 0;
        for (int i = 1; i < 1024; i++) begin
            pop_one();
            if (rd_data !== pat(1000 + i)) bad++;
        end
        chk("R6 drain matches, extra dropped", bad, 0);
        chk("R1 last word", rd_data, pat(2023));
        chk("R3 empty after drain", status[4], 0);
        chk("R6 overflow sticky", overflow, 1);
        wipe_all(1'b0);
        chk("R8 wipe clears overflow", overflow, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset_state();
        t_status_inputs();
        t_order();
        t_empty_pop();
        t_clear_seq();
        t_no_route();
        t_half_irq();
        t_full();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule